// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side logic for an SMBus interrupt line. While any enabled fault source is high it latches an alert and pulls its open-drain alert output low. The bus controller then finds out who is interrupting by issuing a read to the alert response address. Every device that is alerting and has not yet answered acknowledges that read. Each of them then sends its own 7-bit device address as the data byte. They contend on the wired-AND data line with ordinary bitwise arbitration, so the lowest address survives.

A device that loses arbitration drops off the line for the rest of the transfer. It keeps its alert asserted so it can answer a later alert-response read. A device that wins is marked as answered and does not answer again. Its alert is released only when status software signals a status read (`status_read`) at a time when no enabled fault is active.

The receiver is a state machine with six states:

- ST_IDLE: the bus is free.
- ST_ADDR: shifting in the address byte after a START.
- ST_AACK: driving the acknowledge.
- ST_TX: sending the address byte with arbitration.
- ST_MACK: the controller's acknowledge slot.
- ST_WAIT: ignoring the bus until the next START or STOP.

The transitions are:

- START takes any state to ST_ADDR.
- STOP takes any state to ST_IDLE.
- ST_ADDR goes to ST_AACK at the end of the eighth bit when the byte is the alert-response read and the device is eligible. Otherwise it goes to ST_WAIT.
- ST_AACK goes to ST_TX at the end of the acknowledge clock.
- ST_TX goes to ST_WAIT on an arbitration loss.
- ST_TX goes to ST_MACK after eight bits.
- ST_MACK goes to ST_WAIT at the end of the ninth clock.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset `alert_n` is 1, `sda_drive_low` is 0 and the device is marked as not answered.
- R2: One clock after any source with `fault_src[i]` and `fault_en[i]` both high, the alert latches and `alert_n` reads 0. A source whose enable is 0 has no effect on `alert_n`.
- R3: A device whose alert is not latched, or that has already answered, does not acknowledge the alert-response read. The controller sees the ninth bit high.
- R4: A latched device that has not answered acknowledges the address byte 0x19 (address 0001100 followed by read bit 1) by holding SDA low through the ninth clock. It changes its SDA drive only while SCL is low. START is an SDA fall with SCL high, and STOP is an SDA rise with SCL high.
- R5: After acknowledging, the device sends the byte {dev_addr[6:0], 0}, most significant bit first, one bit per SCL clock.
- R6: While sending, if the device leaves SDA released (bit 1) and samples SDA low on an SCL rise, it releases SDA for the rest of the transfer and keeps its alert latched. When several devices contend, the controller therefore reads the lowest address.
- R7: Sending all eight bits without losing marks the device as answered. A loser is not marked, and answers the next alert-response read.
- R8: A `status_read` pulse clears the alert and the answered mark only if the device has answered and no enabled fault is active. Otherwise the pulse leaves `alert_n` at 0.
- R9: Any other address byte, including the alert response address with the write bit (0x18), is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND) |
| dev_addr | input | 7 | This device's bus address |
| fault_src | input | NUM_SRC | Fault condition inputs |
| fault_en | input | NUM_SRC | Per-source alert enables |
| status_read | input | 1 | One-cycle pulse: status registers were read |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain) |
| alert_n | output | 1 | Active-low alert line level driven by this device |

## Verification
The hardest situation to reach is arbitration loss. Only another device driving the same wire can produce it, so the bench instantiates two responders on a shared wired-AND SDA line together with a bit-banging controller. The bench sweeps many address pairs with different bit patterns, so the first differing bit falls at many positions. For each pair it reads twice and expects first the lower address, then the higher one, both computed arithmetically. It also checks that a third read goes unacknowledged. The clearing rule is reached by ordering status pulses before the answer, while the fault is still present, and after it has gone.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;
    localparam logic [BYTE_W-1:0] ARA_READ_BYTE = {ARA_ADDR, 1'b1};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } ara_state_e;

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_p;
    logic              sda_p;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_in;
                        sda_chain[0] <= sda_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        scl_chain[g] <= 1'b1;
                        sda_chain[g] <= 1'b1;
                    end else begin
                        scl_chain[g] <= scl_chain[g-1];
                        sda_chain[g] <= sda_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_chain[STAGES-1];
            sda_p <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_det, stop_det})); // R4

endmodule

// File: rtl/smb_alert_latch.sv
module smb_alert_latch #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fault_src,
    input  logic [NUM_SRC-1:0] fault_en,
    input  logic               resp_done,
    input  logic               status_read,
    output logic               alert_q,
    output logic               eligible
);

    logic fault_any;
    logic responded_q;
    logic clear_ok;

    assign fault_any = |(fault_src & fault_en);
    assign clear_ok  = status_read & responded_q & ~fault_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_q     <= 1'b0;
            responded_q <= 1'b0;
        end else begin
            if (fault_any)
                alert_q <= 1'b1;
            else if (clear_ok)
                alert_q <= 1'b0;

            if (clear_ok)
                responded_q <= 1'b0;
            else if (resp_done)
                responded_q <= 1'b1;
        end
    end

    assign eligible = alert_q & ~responded_q;

    AST_FAULT_ALERTS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> alert_q); // R2
    AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_q && !status_read) |=> alert_q); // R8
    AST_RESP_ONLY_ALERTING: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> (alert_q && !responded_q)); // R7

endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
    import smb_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              eligible,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              sda_low,
    output logic              resp_done
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    ara_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] rx_q, rx_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic              lost;

    assign lost = (state_q == ST_TX) && scl_rise && tx_q[BYTE_W-1] && !sda_s
                  && !start_det && !stop_det;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rx_q    <= rx_d;
            tx_q    <= tx_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rx_d    = rx_q;
        tx_d    = tx_q;
        if (start_det) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        rx_d  = {rx_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST_BIT) begin
                        state_d = (rx_q == ARA_READ_BYTE && eligible) ? ST_AACK : ST_WAIT;
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        state_d = ST_TX;
                        tx_d    = {dev_addr, 1'b0};
                        cnt_d   = '0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        if (tx_q[BYTE_W-1] && !sda_s)
                            state_d = ST_WAIT;
                        else
                            cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == LAST_BIT)
                            state_d = ST_MACK;
                        else
                            tx_d = {tx_q[BYTE_W-2:0], 1'b1};
                    end
                end
                ST_MACK: begin
                    if (scl_fall)
                        state_d = ST_WAIT;
                end
                ST_WAIT: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_low   = 1'b0;
        resp_done = 1'b0;
        unique case (state_q)
            ST_AACK: sda_low = 1'b1;
            ST_TX: begin
                sda_low   = ~tx_q[BYTE_W-1];
                resp_done = scl_fall && (cnt_q == LAST_BIT) && !start_det && !stop_det;
            end
            default: sda_low = 1'b0;
        endcase
    end

    AST_ACK_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AACK) |-> eligible); // R3
    AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !start_det && !stop_det) |-> $stable(sda_low)); // R4
    AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> (!sda_low && !resp_done)); // R6

endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
    import smb_alert_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [ADDR_W-1:0]  dev_addr,
    input  logic [NUM_SRC-1:0] fault_src,
    input  logic [NUM_SRC-1:0] fault_en,
    input  logic               status_read,
    output logic               sda_drive_low,
    output logic               alert_n
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic alert_q, eligible, resp_done;

    smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_alert_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_src   (fault_src),
        .fault_en    (fault_en),
        .resp_done   (resp_done),
        .status_read (status_read),
        .alert_q     (alert_q),
        .eligible    (eligible)
    );

    smb_ara_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .eligible  (eligible),
        .dev_addr  (dev_addr),
        .sda_low   (sda_drive_low),
        .resp_done (resp_done)
    );

    assign alert_n = ~alert_q;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (alert_n || !$past(alert_n))); // R1

endmodule

// File: tb/smb_alert_responder_test.sv
module smb_alert_responder_test;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic [6:0] addr_a = 7'h35;
    logic [6:0] addr_b = 7'h2A;
    logic [3:0] fsrc_a = '0, fsrc_b = '0, fen_a = '0, fen_b = '0;
    logic sr_a = 1'b0, sr_b = 1'b0;
    logic drv_a, drv_b, aln_a, aln_b;
    wire  sda_bus = ~(m_sda_low | drv_a | drv_b);

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smb_alert_responder uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .dev_addr(addr_a), .fault_src(fsrc_a), .fault_en(fen_a),
        .status_read(sr_a), .sda_drive_low(drv_a), .alert_n(aln_a)
    );

    smb_alert_responder uut_b (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .dev_addr(addr_b), .fault_src(fsrc_b), .fault_en(fen_b),
        .status_read(sr_b), .sda_drive_low(drv_b), .alert_n(aln_b)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl = 1'b1; hold(H);
        m_sda_low = 1'b1; hold(H);
        m_scl = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda_low = 1'b0; hold(H);
    endtask

    task automatic clock_bit(input logic b_out, output logic b_in);
        m_sda_low = ~b_out; hold(H);
        m_scl = 1'b1; hold(H/2);
        b_in = sda_bus; hold(H/2);
        m_scl = 1'b0; hold(2);
    endtask

    task automatic xact(input logic [7:0] abyte, output logic ack, output logic [7:0] data);
        logic b;
        bus_start();
        for (int i = 7; i >= 0; i--) clock_bit(abyte[i], b);
        clock_bit(1'b1, ack);
        data = 8'hFF;
        if (!ack) begin
            for (int i = 7; i >= 0; i--) begin
                clock_bit(1'b1, b);
                data[i] = b;
            end
            clock_bit(1'b1, b);
        end
        bus_stop();
    endtask

    task automatic pulse_sr_a();
        sr_a = 1'b1; hold(1); sr_a = 1'b0; hold(2);
    endtask

    task automatic pulse_sr_b();
        sr_b = 1'b1; hold(1); sr_b = 1'b0; hold(2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hold(3); rst_n = 1'b1; hold(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] data;
        logic [6:0] a, b, lo, hi;
        do_reset();
        // R1 reset state
        check("R1 alert_n a", aln_a, 1);
        check("R1 alert_n b", aln_b, 1);
        check("R1 drive", drv_a | drv_b, 0);

        // R3 nobody alerting: no ACK
        xact(8'h19, ack, data);
        check("R3 no ack idle", ack, 1);

        // R2 disabled source ignored
        fsrc_a = 4'b0001; fen_a = 4'b1110; hold(3);
        check("R2 disabled source", aln_a, 1);
        fen_a = 4'b0001; hold(2);
        check("R2 enabled source", aln_a, 0);

        // R8 status read before answer does not clear
        fsrc_a = '0; hold(1); pulse_sr_a();
        check("R8 read before answer", aln_a, 0);
        fsrc_a = 4'b0001;

        // R9 other address and ARA write not acked
        xact({7'h50, 1'b1}, ack, data);
        check("R9 other address", ack, 1);
        xact(8'h18, ack, data);
        check("R9 ara write", ack, 1);

        // R4 R5 R6 two alerting devices: lowest wins
        fsrc_b = 4'b0100; fen_b = 4'b0100; hold(2);
        check("R2 b alert", aln_b, 0);
        xact(8'h19, ack, data);
        check("R4 ack", ack, 0);
        check("R5 R6 winner byte", data, {7'h2A, 1'b0});
        check("R6 loser keeps alert", aln_a, 0);
        // R7 loser answers next, winner silent
        xact(8'h19, ack, data);
        check("R7 second ack", ack, 0);
        check("R7 loser byte", data, {7'h35, 1'b0});
        xact(8'h19, ack, data);
        check("R3 R7 all answered", ack, 1);

        // R8 clearing rule
        pulse_sr_b();
        check("R8 fault still present", aln_b, 0);
        fsrc_b = '0; hold(1); pulse_sr_b();
        check("R8 cleared", aln_b, 1);
        fsrc_a = '0; hold(1); pulse_sr_a();
        check("R8 cleared a", aln_a, 1);

        // R6 R5 sweep over address pairs
        for (int i = 0; i < 24; i++) begin
            a = 7'((i * 37 + 5) % 128);
            b = 7'((i * 53 + 11) % 128);
            if (a == b) b = a ^ 7'd1;
            lo = (a < b) ? a : b;
            hi = (a < b) ? b : a;
            addr_a = a; addr_b = b;
            fsrc_a = 4'b1000; fen_a = 4'b1000;
            fsrc_b = 4'b0010; fen_b = 4'b0010;
            do_reset();
            xact(8'h19, ack, data);
            check("R6 sweep ack1", ack, 0);
            check("R6 sweep low first", data, {lo, 1'b0});
            xact(8'h19, ack, data);
            check("R7 sweep ack2", ack, 0);
            check("R5 sweep high second", data, {hi, 1'b0});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule